// File: doc/BRIEF.md
# Video Fetch Address Generator

This block supplies the memory address from which a display controller pulls pixel data. Software programs a frame start address one byte at a time. A separate running fetch pointer is loaded from that start address on every vertical blank, and it moves forward by one 64-bit word each time the display side strobes a fetch. Because each fetch is eight bytes wide, both the start address and the pointer stay 8-byte aligned. Software may also overwrite the running pointer at any time, and the change applies to the very next fetch.

The block also stores the display mode and turns the 3-bit mode code into the visible width, the line count and the number of bit planes. A monitor-detect input forces the monochrome high-resolution mode, which software cannot select on its own. In the two modes with a short vertical resolution every scan line is drawn twice. For those modes the block raises a line-doubling flag, and its end-of-line event fires only after the second copy of each line. A narrow legacy mode register shares storage with the extended mode register.

Top module: `vfa_top`

## Requirements
- R1: After reset, fetch_addr is 0, mode_out is 000 with its geometry (320, 200, 4 planes), hline_evt is 0, and the base, counter and mode registers read back as 0.
- R2: Register indices 0, 1 and 2 hold the high, middle and low bytes of the 24-bit frame base. Writes to index 2 store the byte with bits 2:0 cleared. The bytes read back through reg_rdata.
- R3: When vblank is high at a clock edge, the counter is loaded from the base, and fetch_addr shows that value after the edge. This load wins over a counter write or a fetch strobe in the same cycle.
- R4: Each cycle with fetch_stb high (and no vblank and no counter write) advances fetch_addr by 8, wrapping modulo 2^24.
- R5: Register indices 3, 4 and 5 read the high, middle and low counter bytes. A write to one of them replaces that byte at the edge, with bits 2:0 of the low byte cleared, so the next fetch uses the new value. Such a write wins over a fetch strobe in the same cycle.
- R6: A write to index 7 selects mode wdata[2:0]. A write to index 6 selects mode {0, wdata[1:0]}. Writes that would select 011, 101 or 110 are ignored and leave the mode unchanged.
- R7: While mon_hi is high, the effective mode is 110 regardless of the stored mode. When mon_hi falls, the stored mode returns.
- R8: mode_out, hpix, vlin and planes follow the effective mode: 000=320/200/4, 001=640/200/2, 010=640/400/1, 100=640/480/4, 110=1280/960/1, 111=320/480/8.
- R9: line_dbl is 1 exactly in modes 000 and 001. In those modes hline_evt pulses on every second line_end, counted from the last vblank. In all other modes it pulses on every line_end. The pulse appears in the cycle after the line_end.
- R10: Index 7 reads {00000, effective mode}. Index 6 reads {000000, mode[1:0]} when the effective mode's bit 2 is 0, and reads all three mode bits ({00000, mode}) when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register index |
| reg_wdata | input | 8 | Register write byte |
| reg_rdata | output | 8 | Registered read byte, one cycle after reg_addr |
| fetch_stb | input | 1 | One 64-bit fetch consumed this cycle |
| vblank | input | 1 | Vertical blank reload pulse |
| line_end | input | 1 | End of a drawn scan line |
| mon_hi | input | 1 | High-resolution monochrome monitor detected |
| fetch_addr | output | 8*NBYTES | Current fetch address |
| mode_out | output | 3 | Effective display mode |
| hpix | output | 11 | Visible pixels per line |
| vlin | output | 10 | Visible lines per frame |
| planes | output | 4 | Bit planes per pixel |
| line_dbl | output | 1 | Every line drawn twice |
| hline_evt | output | 1 | Horizontal line event pulse |

## Verification
The assertions assume that vblank, fetch_stb and line_end are single-cycle or level strobes sampled at the clock, and that reg_addr is stable in any cycle where a read result is awaited. They do not assume any spacing between a register write and a fetch strobe. The stimulus drives every input half a cycle away from the sampling edge. It mixes random base writes, counter writes, reloads and strobe bursts, including reloads and counter writes that coincide with strobes, so every priority case stays inside legal input behaviour.

// File: rtl/vfa_pkg.sv
package vfa_pkg;
  localparam int MODE_W = 3;
  localparam int HPIX_W = 11;
  localparam int VLIN_W = 10;
  localparam int PLN_W  = 4;

  typedef enum logic [MODE_W-1:0] {
    VM_LO   = 3'd0,
    VM_MID  = 3'd1,
    VM_HI   = 3'd2,
    VM_RSV3 = 3'd3,
    VM_WIDE = 3'd4,
    VM_RSV5 = 3'd5,
    VM_MONO = 3'd6,
    VM_DEEP = 3'd7
  } vmode_e;

  typedef struct packed {
    logic [HPIX_W-1:0] hpix;
    logic [VLIN_W-1:0] vlin;
    logic [PLN_W-1:0]  planes;
  } vgeom_t;

  function automatic logic sw_selectable(input logic [MODE_W-1:0] c);
    case (vmode_e'(c))
      VM_LO, VM_MID, VM_HI, VM_WIDE, VM_DEEP: return 1'b1;
      default:                                return 1'b0;
    endcase
  endfunction

  function automatic logic is_doubled(input logic [MODE_W-1:0] c);
    return (vmode_e'(c) == VM_LO) || (vmode_e'(c) == VM_MID);
  endfunction

  function automatic logic is_extended(input logic [MODE_W-1:0] c);
    return c[MODE_W-1];
  endfunction

  function automatic vgeom_t geom_of(input logic [MODE_W-1:0] c);
    vgeom_t g;
    case (vmode_e'(c))
      VM_LO:   g = '{hpix: 11'd320,  vlin: 10'd200, planes: 4'd4};
      VM_MID:  g = '{hpix: 11'd640,  vlin: 10'd200, planes: 4'd2};
      VM_HI:   g = '{hpix: 11'd640,  vlin: 10'd400, planes: 4'd1};
      VM_WIDE: g = '{hpix: 11'd640,  vlin: 10'd480, planes: 4'd4};
      VM_MONO: g = '{hpix: 11'd1280, vlin: 10'd960, planes: 4'd1};
      VM_DEEP: g = '{hpix: 11'd320,  vlin: 10'd480, planes: 4'd8};
      default: g = '0;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/vfa_base_regs.sv
module vfa_base_regs #(
  parameter int NBYTES     = 3,
  parameter int REG_AW     = 4,
  parameter int ALIGN_BITS = 3,
  parameter int BASE_IDX0  = 0,
  localparam int ADDR_W    = 8 * NBYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [ADDR_W-1:0] base
);
  logic [7:0] byte_q [NBYTES];

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    localparam logic [7:0] KEEP = (i == NBYTES - 1) ? ~8'((1 << ALIGN_BITS) - 1) : 8'hFF;
    always_ff @(posedge clk) begin
      if (rst) begin
        byte_q[i] <= '0;
      end else if (we && addr == REG_AW'(BASE_IDX0 + i)) begin
        byte_q[i] <= wdata & KEEP;
      end
    end
    assign base[(NBYTES-1-i)*8 +: 8] = byte_q[i];
  end

  // R2: the frame base never holds a misaligned address
  p_base_align_r2: assert property (@(posedge clk) disable iff (rst)
    base[ALIGN_BITS-1:0] == '0);
endmodule

// File: rtl/vfa_fetch_ctr.sv
module vfa_fetch_ctr #(
  parameter int NBYTES     = 3,
  parameter int REG_AW     = 4,
  parameter int ALIGN_BITS = 3,
  parameter int CNT_IDX0   = 3,
  localparam int ADDR_W    = 8 * NBYTES,
  localparam int STEP      = 1 << ALIGN_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              vblank,
  input  logic              fetch_stb,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] cnt_q
);
  logic              cpu_hit;
  logic [ADDR_W-1:0] nxt;

  assign cpu_hit = we && (addr >= REG_AW'(CNT_IDX0)) && (addr < REG_AW'(CNT_IDX0 + NBYTES));

  always_comb begin
    nxt = cnt_q;
    if (vblank) begin
      nxt = base;
    end else if (cpu_hit) begin
      for (int i = 0; i < NBYTES; i++) begin
        if (addr == REG_AW'(CNT_IDX0 + i)) nxt[(NBYTES-1-i)*8 +: 8] = wdata;
      end
      nxt[ALIGN_BITS-1:0] = '0;
    end else if (fetch_stb) begin
      nxt = cnt_q + ADDR_W'(STEP);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= nxt;
  end

  // R5: the live pointer stays word aligned after any write
  p_align_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_q[ALIGN_BITS-1:0] == '0);
  // R3: a blank pulse reloads from the base
  p_reload_r3: assert property (@(posedge clk) disable iff (rst)
    vblank |=> cnt_q == $past(base));
  // R4: an unobstructed strobe steps one word
  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    (fetch_stb && !vblank && !cpu_hit) |=> cnt_q == $past(cnt_q) + ADDR_W'(STEP));
  // R4: with nothing happening the pointer holds
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!fetch_stb && !vblank && !cpu_hit) |=> $stable(cnt_q));
endmodule

// File: rtl/vfa_mode_reg.sv
module vfa_mode_reg
  import vfa_pkg::*;
#(
  parameter int REG_AW  = 4,
  parameter int LEG_IDX = 6,
  parameter int EXT_IDX = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [MODE_W-1:0] wdata,
  output logic [MODE_W-1:0] mode_q
);
  logic [MODE_W-1:0] req;
  logic              hit;

  always_comb begin
    hit = 1'b0;
    req = mode_q;
    if (we && addr == REG_AW'(EXT_IDX)) begin
      hit = 1'b1;
      req = wdata;
    end else if (we && addr == REG_AW'(LEG_IDX)) begin
      hit = 1'b1;
      req = {1'b0, wdata[MODE_W-2:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= VM_LO;
    else if (hit && sw_selectable(req)) mode_q <= req;
  end

  // R6: stored mode is never a reserved or hardware-only code
  p_no_rsvd_r6: assert property (@(posedge clk) disable iff (rst)
    mode_q != VM_RSV3 && mode_q != VM_RSV5 && mode_q != VM_MONO);
endmodule

// File: rtl/vfa_mode_decode.sv
module vfa_mode_decode
  import vfa_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode_eff,
  input  logic              line_end,
  input  logic              vblank,
  output logic [MODE_W-1:0] mode_out,
  output logic [HPIX_W-1:0] hpix,
  output logic [VLIN_W-1:0] vlin,
  output logic [PLN_W-1:0]  planes,
  output logic              line_dbl,
  output logic              hline_evt
);
  localparam vgeom_t RST_GEOM = geom_of(VM_LO);
  vgeom_t g;
  logic   dbl;
  logic   second_q;

  assign g   = geom_of(mode_eff);
  assign dbl = is_doubled(mode_eff);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_out <= VM_LO;
      hpix     <= RST_GEOM.hpix;
      vlin     <= RST_GEOM.vlin;
      planes   <= RST_GEOM.planes;
      line_dbl <= 1'b1;
    end else begin
      mode_out <= mode_eff;
      hpix     <= g.hpix;
      vlin     <= g.vlin;
      planes   <= g.planes;
      line_dbl <= dbl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || vblank) begin
      second_q  <= 1'b0;
      hline_evt <= 1'b0;
    end else if (line_end) begin
      if (dbl) begin
        hline_evt <= second_q;
        second_q  <= !second_q;
      end else begin
        hline_evt <= 1'b1;
        second_q  <= 1'b0;
      end
    end else begin
      hline_evt <= 1'b0;
    end
  end

  // R9: single-drawn modes report every line
  p_every_line_r9: assert property (@(posedge clk) disable iff (rst)
    (line_end && !vblank && !dbl) |=> hline_evt);
  // R9: the first copy of a doubled line raises no event
  p_first_copy_r9: assert property (@(posedge clk) disable iff (rst)
    (line_end && !vblank && dbl && !second_q) |=> !hline_evt);
  // R9: no event without a line end
  p_no_spur_r9: assert property (@(posedge clk) disable iff (rst)
    !line_end |=> !hline_evt);
endmodule

// File: rtl/vfa_top.sv
module vfa_top
  import vfa_pkg::*;
#(
  parameter int NBYTES     = 3,
  parameter int REG_AW     = 4,
  parameter int ALIGN_BITS = 3,
  localparam int ADDR_W    = 8 * NBYTES,
  localparam int BASE_IDX0 = 0,
  localparam int CNT_IDX0  = NBYTES,
  localparam int LEG_IDX   = 2 * NBYTES,
  localparam int EXT_IDX   = 2 * NBYTES + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              fetch_stb,
  input  logic              vblank,
  input  logic              line_end,
  input  logic              mon_hi,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [MODE_W-1:0] mode_out,
  output logic [HPIX_W-1:0] hpix,
  output logic [VLIN_W-1:0] vlin,
  output logic [PLN_W-1:0]  planes,
  output logic              line_dbl,
  output logic              hline_evt
);
  logic [ADDR_W-1:0] base;
  logic [MODE_W-1:0] mode_q;
  logic [MODE_W-1:0] mode_eff;
  logic [7:0]        rd_nxt;

  vfa_base_regs #(.NBYTES(NBYTES), .REG_AW(REG_AW), .ALIGN_BITS(ALIGN_BITS),
                  .BASE_IDX0(BASE_IDX0)) i_base (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata), .base(base)
  );

  vfa_fetch_ctr #(.NBYTES(NBYTES), .REG_AW(REG_AW), .ALIGN_BITS(ALIGN_BITS),
                  .CNT_IDX0(CNT_IDX0)) i_ctr (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .vblank(vblank), .fetch_stb(fetch_stb), .base(base), .cnt_q(fetch_addr)
  );

  vfa_mode_reg #(.REG_AW(REG_AW), .LEG_IDX(LEG_IDX), .EXT_IDX(EXT_IDX)) i_mode (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata[MODE_W-1:0]), .mode_q(mode_q)
  );

  assign mode_eff = mon_hi ? VM_MONO : mode_q;

  vfa_mode_decode i_dec (
    .clk(clk), .rst(rst), .mode_eff(mode_eff), .line_end(line_end), .vblank(vblank),
    .mode_out(mode_out), .hpix(hpix), .vlin(vlin), .planes(planes),
    .line_dbl(line_dbl), .hline_evt(hline_evt)
  );

  always_comb begin
    rd_nxt = '0;
    for (int i = 0; i < NBYTES; i++) begin
      if (reg_addr == REG_AW'(BASE_IDX0 + i)) rd_nxt = base[(NBYTES-1-i)*8 +: 8];
      if (reg_addr == REG_AW'(CNT_IDX0 + i))  rd_nxt = fetch_addr[(NBYTES-1-i)*8 +: 8];
    end
    if (reg_addr == REG_AW'(LEG_IDX))
      rd_nxt = is_extended(mode_eff) ? 8'(mode_eff) : 8'(mode_eff[MODE_W-2:0]);
    if (reg_addr == REG_AW'(EXT_IDX)) rd_nxt = 8'(mode_eff);
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_nxt;
  end

  // R7: monitor detect overrides the stored mode
  p_force_r7: assert property (@(posedge clk) disable iff (rst)
    mon_hi |=> mode_out == VM_MONO);
  // R10: legacy reads expose the whole code in extended modes
  p_alias_r10: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == REG_AW'(LEG_IDX) && mode_eff[MODE_W-1]) |=> reg_rdata[MODE_W-1]);
endmodule

// File: tb/test_vfa_top.sv
module test_vfa_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        fetch_stb = 1'b0;
  logic        vblank = 1'b0;
  logic        line_end = 1'b0;
  logic        mon_hi = 1'b0;
  logic [23:0] fetch_addr;
  logic [2:0]  mode_out;
  logic [10:0] hpix;
  logic [9:0]  vlin;
  logic [3:0]  planes;
  logic        line_dbl;
  logic        hline_evt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [23:0] exp_base = '0;
  logic [23:0] exp_cnt = '0;
  logic [2:0]  exp_mode = '0;

  vfa_top i_vfa_top (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .fetch_stb(fetch_stb), .vblank(vblank), .line_end(line_end),
    .mon_hi(mon_hi), .fetch_addr(fetch_addr), .mode_out(mode_out), .hpix(hpix),
    .vlin(vlin), .planes(planes), .line_dbl(line_dbl), .hline_evt(hline_evt)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic ok_code(input logic [2:0] c);
    return c == 3'd0 || c == 3'd1 || c == 3'd2 || c == 3'd4 || c == 3'd7;
  endfunction

  function automatic logic [24:0] geom(input logic [2:0] c);
    case (c)
      3'd0: return {11'd320, 10'd200, 4'd4};
      3'd1: return {11'd640, 10'd200, 4'd2};
      3'd2: return {11'd640, 10'd400, 4'd1};
      3'd4: return {11'd640, 10'd480, 4'd4};
      3'd6: return {11'd1280, 10'd960, 4'd1};
      3'd7: return {11'd320, 10'd480, 4'd8};
      default: return '0;
    endcase
  endfunction

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic base_wr(input int i, input logic [7:0] d);
    wr(4'(i), d);
    exp_base[(2-i)*8 +: 8] = (i == 2) ? (d & 8'hF8) : d;
  endtask

  task automatic cnt_wr(input int i, input logic [7:0] d);
    wr(4'(3 + i), d);
    exp_cnt[(2-i)*8 +: 8] = d;
    exp_cnt[2:0] = '0;
  endtask

  task automatic check_mode(input string req);
    logic [2:0] eff;
    eff = mon_hi ? 3'd6 : exp_mode;
    @(negedge clk);
    check(req, {29'd0, mode_out}, {29'd0, eff});
    check(req, {7'd0, hpix, vlin, planes}, {7'd0, geom(eff)});
    check(req, {31'd0, line_dbl}, {31'd0, (eff == 3'd0 || eff == 3'd1)});
  endtask

  task automatic count_lines(input int n, output int evts);
    evts = 0;
    for (int k = 0; k < n; k++) begin
      line_end = 1'b1;
      @(negedge clk);
      line_end = 1'b0;
      if (hline_evt) evts++;
      @(negedge clk);
      if (hline_evt) evts++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int ev;
    int seed;
    seed = $urandom(32'h1A2B3C);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 fetch_addr", {8'd0, fetch_addr}, 32'd0);
    check("R1 mode_out", {29'd0, mode_out}, 32'd0);
    check("R1 geometry", {7'd0, hpix, vlin, planes}, {7'd0, geom(3'd0)});
    check("R1 hline_evt", {31'd0, hline_evt}, 32'd0);
    for (int i = 0; i < 8; i++) begin
      rd(4'(i), d);
      check("R1 register read", {24'd0, d}, 32'd0);
    end

    // R2 base write with forced alignment
    base_wr(0, 8'h12); base_wr(1, 8'h34); base_wr(2, 8'h5F);
    rd(4'd0, d); check("R2 base high", {24'd0, d}, 32'h12);
    rd(4'd1, d); check("R2 base mid", {24'd0, d}, 32'h34);
    rd(4'd2, d); check("R2 base low aligned", {24'd0, d}, 32'h58);

    // R3 reload
    vblank = 1'b1; @(negedge clk); vblank = 1'b0;
    exp_cnt = exp_base;
    check("R3 reload", {8'd0, fetch_addr}, {8'd0, exp_cnt});

    // R4 stepping and wrap
    fetch_stb = 1'b1; repeat (3) @(negedge clk); fetch_stb = 1'b0;
    exp_cnt = exp_cnt + 24'd24;
    check("R4 three steps", {8'd0, fetch_addr}, {8'd0, exp_cnt});
    cnt_wr(0, 8'hFF); cnt_wr(1, 8'hFF); cnt_wr(2, 8'hFF);
    check("R5 counter written aligned", {8'd0, fetch_addr}, 32'hFFFFF8);
    fetch_stb = 1'b1; @(negedge clk); fetch_stb = 1'b0;
    exp_cnt = 24'd0;
    check("R4 wrap", {8'd0, fetch_addr}, 32'd0);

    // R5 counter readback and write-over-strobe priority
    cnt_wr(1, 8'hA0);
    rd(4'd3, d); check("R5 cnt high", {24'd0, d}, {24'd0, exp_cnt[23:16]});
    rd(4'd4, d); check("R5 cnt mid", {24'd0, d}, 32'hA0);
    rd(4'd5, d); check("R5 cnt low", {24'd0, d}, {24'd0, exp_cnt[7:0]});
    fetch_stb = 1'b1; cnt_wr(2, 8'h40); fetch_stb = 1'b0;
    check("R5 write beats strobe", {8'd0, fetch_addr}, {8'd0, exp_cnt});
    fetch_stb = 1'b1; @(negedge clk); fetch_stb = 1'b0;
    exp_cnt = exp_cnt + 24'd8;
    check("R5 next fetch after write", {8'd0, fetch_addr}, {8'd0, exp_cnt});

    // R3 reload wins over strobe and counter write
    fetch_stb = 1'b1; vblank = 1'b1; wr(4'd4, 8'h77); fetch_stb = 1'b0; vblank = 1'b0;
    exp_cnt = exp_base;
    check("R3 reload priority", {8'd0, fetch_addr}, {8'd0, exp_cnt});

    // random mix R2 R3 R4 R5
    for (int it = 0; it < 300; it++) begin
      int op;
      op = int'($urandom % 5);
      case (op)
        0: base_wr(int'($urandom % 3), 8'($urandom));
        1: begin vblank = 1'b1; @(negedge clk); vblank = 1'b0; exp_cnt = exp_base; end
        2: begin
          int n;
          n = 1 + int'($urandom % 6);
          fetch_stb = 1'b1; repeat (n) @(negedge clk); fetch_stb = 1'b0;
          exp_cnt = exp_cnt + 24'(8 * n);
        end
        3: cnt_wr(int'($urandom % 3), 8'($urandom));
        default: begin
          vblank = 1'b1; fetch_stb = 1'b1; @(negedge clk);
          vblank = 1'b0; fetch_stb = 1'b0; exp_cnt = exp_base;
        end
      endcase
      check("R3/R4/R5 random pointer", {8'd0, fetch_addr}, {8'd0, exp_cnt});
    end
    rd(4'd2, d); check("R2 random base low", {24'd0, d}, {24'd0, exp_base[7:0]});
    rd(4'd0, d); check("R2 random base high", {24'd0, d}, {24'd0, exp_base[23:16]});

    // R6 R8 every code through the extended register
    for (int c = 0; c < 8; c++) begin
      wr(4'd7, 8'(c) | 8'hF8);
      if (ok_code(3'(c))) exp_mode = 3'(c);
      check_mode("R6/R8 extended write");
    end
    // R6 legacy writes
    wr(4'd6, 8'h03); check_mode("R6 legacy reserved ignored");
    wr(4'd6, 8'h02); exp_mode = 3'd2; check_mode("R6 legacy select");
    wr(4'd6, 8'h05); exp_mode = 3'd1; check_mode("R6 legacy drops bit 2");

    // R10 aliasing
    rd(4'd6, d); check("R10 legacy read normal", {24'd0, d}, 32'h01);
    wr(4'd7, 8'h04); exp_mode = 3'd4;
    rd(4'd6, d); check("R10 legacy read extended", {24'd0, d}, 32'h04);
    rd(4'd7, d); check("R10 extended read", {24'd0, d}, 32'h04);

    // R7 monitor force
    mon_hi = 1'b1; check_mode("R7 forced mono");
    wr(4'd7, 8'h07); exp_mode = 3'd7; check_mode("R7 write under force");
    rd(4'd6, d); check("R10 legacy read under force", {24'd0, d}, 32'h06);
    mon_hi = 1'b0; check_mode("R7 release restores stored");

    // R9 line doubling events
    wr(4'd7, 8'h00); exp_mode = 3'd0;
    vblank = 1'b1; @(negedge clk); vblank = 1'b0;
    line_end = 1'b1; @(negedge clk); line_end = 1'b0;
    check("R9 first copy silent", {31'd0, hline_evt}, 32'd0);
    line_end = 1'b1; @(negedge clk); line_end = 1'b0;
    check("R9 second copy fires", {31'd0, hline_evt}, 32'd1);
    @(negedge clk);
    check("R9 pulse one cycle", {31'd0, hline_evt}, 32'd0);
    count_lines(6, ev); check("R9 doubled count", ev, 3);
    wr(4'd7, 8'h01); exp_mode = 3'd1;
    vblank = 1'b1; @(negedge clk); vblank = 1'b0;
    count_lines(4, ev); check("R9 mid doubled count", ev, 2);
    wr(4'd7, 8'h04); exp_mode = 3'd4;
    count_lines(5, ev); check("R9 single count", ev, 5);
    check("R9 line_dbl off", {31'd0, line_dbl}, 32'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule